// File: doc/BRIEF.md
# Cyclic DMA Descriptor Queue

This block sits between software and the transfer engine of one channel of a cyclic audio DMA controller. Software builds each transfer descriptor by writing four 32-bit words in turn to a single register port. The words are the buffer address (low half, then high half), the length in bytes, and a flags word. A descriptor enters the four-slot ring only when its last word arrives. A status word shows where the write and read pointers are, whether the ring is empty or full, and whether an overflow error has been latched.

On the engine side, a pop strobe moves the oldest stored descriptor into an active register set. The block then reports that descriptor's address, length and flags, along with a live residue: the number of bytes still to move. Each transfer beat lowers the residue by its byte count. When the residue reaches zero and the descriptor asked for notification, the block emits a one-cycle pulse. A control bit holds the ring in a flushed state until software releases it.

Top module: `dma_desc_queue`

## Requirements
- R1: After reset, `ring_status` reads 0x100 (empty only), `residue` is 0, and `desc_avail`, `act_busy` and `done_notify` are 0.
- R2: Four writes on `desc_wr_en` form one descriptor, in this order: address bits [31:0], address bits [63:32], length in bytes, flags. The write pointer advances and the descriptor becomes visible only on the fourth write; after one to three words the status is unchanged.
- R3: `ring_status` carries the write slot in bits [1:0], the read slot in bits [5:4], empty in bit 8, full in bit 9 and error in bit 10; all other bits read 0.
- R4: Occupancy is (write − read + 4) mod 4 when the slots differ. When they are equal, exactly one of full or empty is set. Four stored descriptors set full.
- R5: A fourth word arriving while the ring is full sets the error bit. That descriptor is discarded and the write pointer does not move. The stored descriptors then pop out unchanged, in order.
- R6: A status write with bit 10 set clears the error bit. A status write with bit 10 clear leaves it as it is.
- R7: While control bit 0 is 1 (written through `ctl_wr_en`), the ring is held flushed. Both pointers return to 0, the ring reads empty, the error bit clears, any partly written descriptor is dropped, the residue clears and descriptor words are ignored. Writing 0 releases the flush.
- R8: `pop_req` with the ring not empty loads the oldest descriptor into `act_addr`, `act_len` and `act_flags`, sets `residue` to its length and advances the read slot. A pop on an empty ring changes nothing.
- R9: `beat_en` lowers `residue` by `beat_bytes`, stopping at 0. A beat when the residue is already 0 has no effect.
- R10: When a beat brings the residue to 0 and flags bit 16 of the active descriptor is 1, `done_notify` is 1 for exactly one cycle. If bit 16 is 0, no pulse occurs.
- R11: A pop in the same cycle as a beat takes precedence. The residue jumps up to the new descriptor's length, and the beat is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_wr_en | input | 1 | Descriptor word write strobe |
| desc_wr_data | input | 32 | Descriptor word |
| stat_wr_en | input | 1 | Status register write strobe |
| stat_wr_data | input | 32 | Status write data; bit 10 clears error |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 32 | Control write data; bit 0 holds ring flush |
| pop_req | input | 1 | Engine request to load the next descriptor |
| beat_en | input | 1 | One transfer beat completed |
| beat_bytes | input | BEAT_W | Bytes moved by this beat |
| ring_status | output | 32 | Slot pointers, empty, full, error |
| desc_avail | output | 1 | At least one descriptor stored |
| act_addr | output | 64 | Active descriptor address |
| act_len | output | 32 | Active descriptor length |
| act_flags | output | 32 | Active descriptor flags |
| residue | output | 32 | Bytes left in the active descriptor |
| act_busy | output | 1 | Residue is nonzero |
| done_notify | output | 1 | One-cycle completion pulse |

## Verification
The hardest state to reach is an overflow: a full ring with the write pointer wrapped back onto the read pointer while a fifth descriptor completes. The stimulus first pops one descriptor, so the pointers sit away from zero, and then pushes four descriptors to wrap the write slot. It then checks that the error bit sets and the pointers stay put. Popping all four afterwards proves the overflowing descriptor never landed. A second hard case is a flush that arrives with a half-assembled descriptor pending. The bench leaves two words dangling, flushes, and then checks that a fresh descriptor pops out intact rather than merged with the stale words.

// File: rtl/dq_pkg.sv
// Package: shared types and bit positions for the descriptor queue.
// Assumes 32-bit register words and a 64-bit buffer address.
package dq_pkg;
    localparam int WORD_W     = 32;
    localparam int ST_EMPTY   = 8;
    localparam int ST_FULL    = 9;
    localparam int ST_ERR     = 10;
    localparam int NOTIFY_BIT = 16;
    localparam int CTL_FLUSH  = 0;

    typedef struct packed {
        logic [63:0] addr;
        logic [31:0] len;
        logic [31:0] flags;
    } dq_desc_t;
endpackage

// File: rtl/dq_assembler.sv
// Module: dq_assembler
// Collects four sequential 32-bit words into one descriptor and raises
// a commit strobe on the fourth. Assumes words arrive in the order
// addr low, addr high, length, flags. A flush drops any partial words.
module dq_assembler
    import dq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              word_en,
    input  logic [WORD_W-1:0] word_data,
    output logic              commit,
    output dq_desc_t          desc
);
    localparam int WORDS = 4;
    localparam int PH_W  = $clog2(WORDS);

    logic [PH_W-1:0]   phase_q;
    logic [WORD_W-1:0] addr_lo_q;
    logic [WORD_W-1:0] addr_hi_q;
    logic [WORD_W-1:0] len_q;

    // The last word completes a descriptor unless the ring is being flushed.
    assign commit = word_en && !flush && (phase_q == PH_W'(WORDS - 1));

    // Descriptor view: the staged words plus the word now arriving.
    always_comb begin
        desc.addr  = {addr_hi_q, addr_lo_q};
        desc.len   = len_q;
        desc.flags = word_data;
    end

    // Word position counter; wraps after the fourth word, cleared by flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            phase_q <= '0;
        end else if (word_en) begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // Staging registers for the first three words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_lo_q <= '0;
            addr_hi_q <= '0;
            len_q     <= '0;
        end else if (word_en && !flush) begin
            case (phase_q)
                PH_W'(0): addr_lo_q <= word_data;
                PH_W'(1): addr_hi_q <= word_data;
                PH_W'(2): len_q     <= word_data;
                default:  ;
            endcase
        end
    end

    // Counts the words written since the last commit; must trail phase_q.
    logic [PH_W-1:0] words_seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            words_seen_q <= '0;
        end else if (word_en) begin
            words_seen_q <= (words_seen_q == PH_W'(WORDS - 1)) ? '0 : words_seen_q + 1'b1;
        end
    end

    AST_COMMIT_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (words_seen_q == PH_W'(WORDS - 1)))
        else $error("commit before fourth word"); // R2
endmodule

// File: rtl/dq_store.sv
// Module: dq_store
// Ring of DEPTH descriptor slots with write and read pointers, an occupancy
// counter, and a sticky overflow error. Assumes DEPTH is a power of two.
// Flush empties the ring and clears the error.
module dq_store
    import dq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  dq_desc_t                   push_desc,
    input  logic                       pop,
    input  logic                       err_clr,
    output dq_desc_t                   pop_desc,
    output logic                       pop_ok,
    output logic [$clog2(DEPTH)-1:0]   wr_ptr,
    output logic [$clog2(DEPTH)-1:0]   rd_ptr,
    output logic                       full,
    output logic                       empty,
    output logic                       err
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] count_q;
    logic             push_ok;
    dq_desc_t         slot_view [DEPTH];

    assign full    = (count_q == CNT_W'(DEPTH));
    assign empty   = (count_q == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty && !flush;
    assign pop_desc = slot_view[rd_ptr];

    // Slot storage: one register per slot, written when the write pointer selects it.
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        dq_desc_t q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (push_ok && !flush && (wr_ptr == PTR_W'(s))) begin
                q <= push_desc;
            end
        end
        assign slot_view[s] = q;
    end

    // Pointer and occupancy update for accepted pushes and pops.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: ;
            endcase
        end
    end

    // Sticky overflow flag: set on a push into a full ring, set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            err <= 1'b0;
        end else if (push && full) begin
            err <= 1'b1;
        end else if (err_clr) begin
            err <= 1'b0;
        end
    end

    AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty))
        else $error("full and empty together"); // R4
    AST_PTR_EQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr == rd_ptr) |-> (full || empty))
        else $error("equal pointers without full or empty"); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> ($stable(wr_ptr) && err))
        else $error("push into full ring moved pointer"); // R5
    AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !flush) |=> $stable(rd_ptr))
        else $error("pop on empty ring moved pointer"); // R8
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (empty && !err && wr_ptr == '0 && rd_ptr == '0))
        else $error("flush left ring occupied"); // R7
endmodule

// File: rtl/dq_residue.sv
// Module: dq_residue
// Holds the active descriptor and its remaining byte count. A load takes
// precedence over a beat in the same cycle. Raises a one-cycle notify
// pulse when a beat drains the residue of a descriptor with the notify flag.
module dq_residue
    import dq_pkg::*;
#(
    parameter int BEAT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              load,
    input  dq_desc_t          load_desc,
    input  logic              beat_en,
    input  logic [BEAT_W-1:0] beat_bytes,
    output dq_desc_t          act,
    output logic [WORD_W-1:0] residue,
    output logic              done_pulse
);
    logic [WORD_W-1:0] step;
    logic              drains;

    // Beat size limited to what is left, so the count stops at zero.
    always_comb begin
        step   = (WORD_W'(beat_bytes) >= residue) ? residue : WORD_W'(beat_bytes);
        drains = beat_en && (residue != '0) && (step == residue);
    end

    // Active descriptor registers.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            act <= '0;
        end else if (load) begin
            act <= load_desc;
        end
    end

    // Residue count: load with length, lower on each beat.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            residue <= '0;
        end else if (load) begin
            residue <= load_desc.len;
        end else if (beat_en) begin
            residue <= residue - step;
        end
    end

    // Completion pulse for descriptors that request notification.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            done_pulse <= 1'b0;
        end else begin
            done_pulse <= !load && drains && act.flags[NOTIFY_BIT];
        end
    end

    AST_RESIDUE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !flush) |=> (residue == $past(load_desc.len)))
        else $error("residue not loaded with length"); // R8
    AST_RESIDUE_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_en && !load && !flush) |=> (residue <= $past(residue)))
        else $error("residue grew on a beat"); // R9
    AST_NOTIFY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (residue == '0))
        else $error("notify with residue left"); // R10
    AST_NOTIFY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse)
        else $error("notify longer than one cycle"); // R10
endmodule

// File: rtl/dma_desc_queue.sv
// Module: dma_desc_queue (top)
// Per-channel descriptor queue for a cyclic DMA engine: word-wise descriptor
// entry, four-slot ring with status word, flush control, and an active
// descriptor with live residue. Assumes register writes arrive as one-cycle
// strobes and that DEPTH matches the 2-bit slot fields of the status word.
module dma_desc_queue
    import dq_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int BEAT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_wr_en,
    input  logic [31:0]       desc_wr_data,
    input  logic              stat_wr_en,
    input  logic [31:0]       stat_wr_data,
    input  logic              ctl_wr_en,
    input  logic [31:0]       ctl_wr_data,
    input  logic              pop_req,
    input  logic              beat_en,
    input  logic [BEAT_W-1:0] beat_bytes,
    output logic [31:0]       ring_status,
    output logic              desc_avail,
    output logic [63:0]       act_addr,
    output logic [31:0]       act_len,
    output logic [31:0]       act_flags,
    output logic [31:0]       residue,
    output logic              act_busy,
    output logic              done_notify
);
    localparam int PTR_W = $clog2(DEPTH);

    logic             flush_q;
    logic             commit;
    dq_desc_t         new_desc;
    dq_desc_t         head_desc;
    dq_desc_t         act;
    logic             pop_ok;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             full;
    logic             empty;
    logic             err;

    logic unused_bits;
    assign unused_bits = ^{stat_wr_data[31:ST_ERR+1], stat_wr_data[ST_ERR-1:0],
                           ctl_wr_data[31:CTL_FLUSH+1]};

    // Flush control bit: holds both rings empty while set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_q <= 1'b0;
        end else if (ctl_wr_en) begin
            flush_q <= ctl_wr_data[CTL_FLUSH];
        end
    end

    dq_assembler u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush_q),
        .word_en   (desc_wr_en),
        .word_data (desc_wr_data),
        .commit    (commit),
        .desc      (new_desc)
    );

    dq_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush_q),
        .push      (commit),
        .push_desc (new_desc),
        .pop       (pop_req),
        .err_clr   (stat_wr_en && stat_wr_data[ST_ERR]),
        .pop_desc  (head_desc),
        .pop_ok    (pop_ok),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .full      (full),
        .empty     (empty),
        .err       (err)
    );

    dq_residue #(.BEAT_W(BEAT_W)) u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush_q),
        .load       (pop_ok),
        .load_desc  (head_desc),
        .beat_en    (beat_en),
        .beat_bytes (beat_bytes),
        .act        (act),
        .residue    (residue),
        .done_pulse (done_notify)
    );

    // Status word packing: slot fields, then empty, full and error flags.
    always_comb begin
        ring_status           = '0;
        ring_status[1:0]      = 2'(wr_ptr);
        ring_status[5:4]      = 2'(rd_ptr);
        ring_status[ST_EMPTY] = empty;
        ring_status[ST_FULL]  = full;
        ring_status[ST_ERR]   = err;
    end

    // Consumer-side outputs.
    assign desc_avail = !empty;
    assign act_addr   = act.addr;
    assign act_len    = act.len;
    assign act_flags  = act.flags;
    assign act_busy   = (residue != '0);

    AST_STATUS_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_status[31:11] == '0) && (ring_status[7:6] == '0) && (ring_status[3:2] == '0))
        else $error("reserved status bits set"); // R3
    AST_POP_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_ok && beat_en) |=> (residue == act_len))
        else $error("beat won over pop"); // R11
endmodule

// File: tb/test_dma_desc_queue.sv
module test_dma_desc_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        desc_wr_en = 1'b0;
    logic [31:0] desc_wr_data = '0;
    logic        stat_wr_en = 1'b0;
    logic [31:0] stat_wr_data = '0;
    logic        ctl_wr_en = 1'b0;
    logic [31:0] ctl_wr_data = '0;
    logic        pop_req = 1'b0;
    logic        beat_en = 1'b0;
    logic [3:0]  beat_bytes = '0;
    logic [31:0] ring_status;
    logic        desc_avail;
    logic [63:0] act_addr;
    logic [31:0] act_len;
    logic [31:0] act_flags;
    logic [31:0] residue;
    logic        act_busy;
    logic        done_notify;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dma_desc_queue i_dma_desc_queue (
        .clk(clk), .rst_n(rst_n),
        .desc_wr_en(desc_wr_en), .desc_wr_data(desc_wr_data),
        .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .pop_req(pop_req), .beat_en(beat_en), .beat_bytes(beat_bytes),
        .ring_status(ring_status), .desc_avail(desc_avail),
        .act_addr(act_addr), .act_len(act_len), .act_flags(act_flags),
        .residue(residue), .act_busy(act_busy), .done_notify(done_notify)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_word(input logic [31:0] w);
        @(negedge clk); desc_wr_en = 1'b1; desc_wr_data = w;
        @(negedge clk); desc_wr_en = 1'b0;
    endtask

    task automatic push(input logic [63:0] a, input logic [31:0] len, input logic [31:0] fl);
        wr_word(a[31:0]); wr_word(a[63:32]); wr_word(len); wr_word(fl);
    endtask

    task automatic pop();
        @(negedge clk); pop_req = 1'b1;
        @(negedge clk); pop_req = 1'b0;
    endtask

    task automatic beat(input logic [3:0] n);
        @(negedge clk); beat_en = 1'b1; beat_bytes = n;
        @(negedge clk); beat_en = 1'b0;
    endtask

    task automatic stat_write(input logic [31:0] v);
        @(negedge clk); stat_wr_en = 1'b1; stat_wr_data = v;
        @(negedge clk); stat_wr_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 status", ring_status, 64'h100);
        chk("R1 residue", residue, 0);
        chk("R1 outputs", {desc_avail, act_busy, done_notify}, 0);
    endtask

    task automatic t_assemble();
        wr_word(32'h1000); wr_word(32'h0000_00AB); wr_word(32'd48);
        chk("R2 partial invisible", ring_status, 64'h100);
        wr_word(32'h0001_0000);
        chk("R2 R3 commit status", ring_status, 64'h001);
        chk("R4 avail", desc_avail, 1);
        pop();
        chk("R2 R8 addr", act_addr, 64'h0000_00AB_0000_1000);
        chk("R8 len", act_len, 48);
        chk("R8 flags", act_flags, 32'h0001_0000);
        chk("R8 residue loaded", residue, 48);
        chk("R3 R8 status after pop", ring_status, 64'h111);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 4; i++) push(64'h2000 + 64'(i) * 64'h100, 32'd16 + 32'(i), 32'h0);
        chk("R4 full wrapped", ring_status, 64'h211);
        push(64'hDEAD, 32'd99, 32'h0);
        chk("R5 error set pointer held", ring_status, 64'h611);
        stat_write(32'h0000_03FF);
        chk("R6 clear needs bit 10", ring_status, 64'h611);
        stat_write(32'h0000_0400);
        chk("R6 error cleared", ring_status, 64'h211);
        for (int i = 0; i < 4; i++) begin
            pop();
            chk("R5 stored addr", act_addr, 64'h2000 + 64'(i) * 64'h100);
            chk("R5 stored len", act_len, 32'd16 + 32'(i));
        end
        chk("R4 empty again", ring_status, 64'h111);
        pop();
        chk("R8 empty pop status", ring_status, 64'h111);
        chk("R8 empty pop keeps active", act_len, 19);
    endtask

    task automatic t_residue();
        push(64'h3000, 32'd20, 32'h0001_0000);
        pop();
        beat(4'd8);
        chk("R9 residue 12", residue, 12);
        chk("R10 no early notify", done_notify, 0);
        beat(4'd8);
        chk("R9 residue 4", residue, 4);
        beat(4'd8);
        chk("R9 saturate at 0", residue, 0);
        chk("R10 notify pulse", done_notify, 1);
        @(negedge clk);
        chk("R10 pulse one cycle", done_notify, 0);
        beat(4'd5);
        chk("R9 beat at zero", residue, 0);
        chk("R10 no pulse at zero", done_notify, 0);
        push(64'h3100, 32'd8, 32'h0);
        pop();
        beat(4'd8);
        chk("R10 flag clear residue", residue, 0);
        chk("R10 flag clear no pulse", done_notify, 0);
    endtask

    task automatic t_jump();
        push(64'h4000, 32'd40, 32'h0);
        push(64'h4100, 32'd64, 32'h0);
        pop();
        beat(4'd10);
        chk("R9 residue 30", residue, 30);
        @(negedge clk); pop_req = 1'b1; beat_en = 1'b1; beat_bytes = 4'd10;
        @(negedge clk); pop_req = 1'b0; beat_en = 1'b0;
        chk("R11 residue jumps", residue, 64);
        chk("R11 new addr", act_addr, 64'h4100);
    endtask

    task automatic t_flush();
        push(64'h5000, 32'd12, 32'h0);
        push(64'h5100, 32'd12, 32'h0);
        wr_word(32'hBAD0); wr_word(32'hBAD1);
        @(negedge clk); ctl_wr_en = 1'b1; ctl_wr_data = 32'h1;
        @(negedge clk); ctl_wr_en = 1'b0; desc_wr_en = 1'b1; desc_wr_data = 32'hBAD2;
        @(negedge clk); desc_wr_en = 1'b0; ctl_wr_en = 1'b1; ctl_wr_data = 32'h0;
        @(negedge clk); ctl_wr_en = 1'b0;
        chk("R7 ring empty, pointers 0", ring_status, 64'h100);
        chk("R7 residue cleared", residue, 0);
        push(64'h0000_0007_0000_6000, 32'd24, 32'h0);
        chk("R7 one new entry", ring_status, 64'h001);
        pop();
        chk("R7 partial dropped addr", act_addr, 64'h0000_0007_0000_6000);
        chk("R7 partial dropped len", act_len, 24);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_assemble();
        t_overflow();
        t_residue();
        t_jump();
        t_flush();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule